// File: doc/BRIEF.md
# Packed Saturating and Halving Adder

This combinational datapath adds or subtracts two 32-bit operands and post-processes each result so that it never wraps. A packing field splits the word into one 32-bit lane, four 8-bit lanes or two 16-bit lanes. Each lane computes its exact result one bit wider than the lane. It then either clamps that result into the lane's range (saturating mode) or drops its lowest bit (halving mode). Both signed and unsigned interpretations are available.

A single ripple array of 8-bit slices does all the addition. The carry into each slice comes either from the slice below or from the subtract control, depending on whether a lane starts at that slice. The per-lane fix-up logic is built once for each packing variant, and the packing field selects one of them. The reserved packing code raises an error flag and forces the result to zero.

Top module: `sath_packed_alu`

## Requirements
- R1: With `pack_i` = 2'b00 the word is one 32-bit lane, and carries propagate across all 32 bits.
- R2: With `pack_i` = 2'b01 the word is four independent 8-bit lanes. No carry or borrow crosses bit 8, 16 or 24.
- R3: With `pack_i` = 2'b10 the word is two independent 16-bit lanes. The carry chain is broken only at bit 16.
- R4: With `pack_i` = 2'b11, `bad_mode_o` is 1 and `result_o` is zero. For every other code, `bad_mode_o` is 0.
- R5: Signed saturating mode (`signed_i`=1, `halve_i`=0) clamps a lane to its maximum (0x7F, 0x7FFF, 0x7FFFFFFF) on positive overflow and to its minimum (0x80, 0x8000, 0x80000000) on negative overflow.
- R6: Unsigned saturating add (`signed_i`=0, `sub_i`=0, `halve_i`=0) returns all ones in a lane that carries out.
- R7: Unsigned saturating subtract (`signed_i`=0, `sub_i`=1, `halve_i`=0) returns zero in a lane that borrows.
- R8: Halving mode (`halve_i`=1) returns bits [w:1] of the exact (w+1)-bit sum or difference of each w-bit lane. In signed mode this rounds toward negative infinity, and in unsigned mode it rounds down.
- R9: In saturating mode, a lane whose exact result fits the lane's range returns that exact result. `sub_i`=1 selects a minus b, and `sub_i`=0 selects a plus b.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 32 | First operand (minuend for subtract) |
| opb_i | input | 32 | Second operand |
| pack_i | input | 2 | Lane split: 00 word, 01 bytes, 10 half-words, 11 reserved |
| sub_i | input | 1 | 1 subtracts, 0 adds |
| signed_i | input | 1 | 1 treats lanes as two's complement, 0 as unsigned |
| halve_i | input | 1 | 1 halves the exact result, 0 saturates it |
| result_o | output | 32 | Packed lane results |
| bad_mode_o | output | 1 | Reserved packing code was presented |

## Verification
The checker's properties assume the inputs are stable, known two-state values whenever it evaluates the outputs, because the block has no clock and the properties compare its inputs with its outputs directly. The bench therefore changes every input together on one clock edge and samples the outputs half a period later. The bench draws its random operands and controls from a deterministic generator, so no input is ever left undriven. The word-mode properties cover only the control combinations they name, and the byte-lane property covers only unsigned saturating addition. The bench reaches the other combinations through its reference model.

// File: rtl/sath_pkg.sv
package sath_pkg;

    typedef enum logic [1:0] {
        PK_WORD = 2'b00,
        PK_BYTE = 2'b01,
        PK_HALF = 2'b10,
        PK_RSVD = 2'b11
    } pack_e;

    typedef struct packed {
        logic sub;
        logic sgn;
        logic halve;
    } opsel_t;

    // Bit w of the exact (w+1)-bit result: the extension bits of a and of
    // the (possibly inverted) b, plus the carry out of the lane's top bit.
    function automatic logic lane_top(input logic sgn, input logic sub,
                                      input logic a_msb, input logic bx_msb,
                                      input logic cout);
        logic ext_a;
        logic ext_b;
        ext_a = sgn & a_msb;
        ext_b = sgn ? bx_msb : sub;
        return ext_a ^ ext_b ^ cout;
    endfunction

    // True when slice k is the lowest slice of a lane in the given split.
    function automatic logic slice_opens_lane(input pack_e pk, input int k);
        case (pk)
            PK_BYTE: return 1'b1;
            PK_HALF: return (k % 2) == 0;
            default: return k == 0;
        endcase
    endfunction

endpackage

// File: rtl/sath_slice.sv
module sath_slice #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    assign {cout_o, sum_o} = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
endmodule

// File: rtl/sath_lane_fix.sv
module sath_lane_fix
    import sath_pkg::*;
#(
    parameter int LW = 8
) (
    input  logic [LW-1:0] sum_i,
    input  logic          top_i,
    input  opsel_t        sel_i,
    output logic [LW-1:0] res_o
);
    localparam logic [LW-1:0] SMAX = {1'b0, {(LW-1){1'b1}}};
    localparam logic [LW-1:0] SMIN = {1'b1, {(LW-1){1'b0}}};

    always_comb begin
        if (sel_i.halve) begin
            res_o = {top_i, sum_i[LW-1:1]};
        end else if (sel_i.sgn) begin
            if (top_i != sum_i[LW-1]) res_o = top_i ? SMIN : SMAX;
            else                      res_o = sum_i;
        end else begin
            if (top_i) res_o = sel_i.sub ? '0 : '1;
            else       res_o = sum_i;
        end
    end
endmodule

// File: rtl/sath_packed_alu.sv
module sath_packed_alu
    import sath_pkg::*;
#(
    parameter int SLICE_W    = 8,
    parameter int NUM_SLICES = 4
) (
    input  logic [31:0] opa_i,
    input  logic [31:0] opb_i,
    input  logic [1:0]  pack_i,
    input  logic        sub_i,
    input  logic        signed_i,
    input  logic        halve_i,
    output logic [31:0] result_o,
    output logic        bad_mode_o
);
    localparam int DATA_W   = SLICE_W * NUM_SLICES;
    localparam int NUM_VARS = 3;

    pack_e                            pk;
    opsel_t                           sel;
    logic [DATA_W-1:0]                bx;
    logic [DATA_W-1:0]                sum_all;
    logic [NUM_SLICES-1:0]            cin_s;
    logic [NUM_SLICES-1:0]            cout_s;
    logic [NUM_VARS-1:0][DATA_W-1:0]  var_res;

    assign pk  = pack_e'(pack_i);
    assign sel = '{sub: sub_i, sgn: signed_i, halve: halve_i};
    assign bx  = opb_i ^ {DATA_W{sub_i}};

    for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
        if (k == 0) begin : g_first
            assign cin_s[k] = sub_i;
        end else begin : g_rest
            assign cin_s[k] = slice_opens_lane(pk, k) ? sub_i : cout_s[k-1];
        end
        sath_slice #(.W(SLICE_W)) u_slice (
            .a_i   (opa_i[k*SLICE_W +: SLICE_W]),
            .b_i   (bx[k*SLICE_W +: SLICE_W]),
            .cin_i (cin_s[k]),
            .sum_o (sum_all[k*SLICE_W +: SLICE_W]),
            .cout_o(cout_s[k])
        );
    end

    // Variant 0: one word lane, 1: byte lanes, 2: half-word lanes.
    for (genvar v = 0; v < NUM_VARS; v++) begin : g_var
        localparam int SPAN = (v == 0) ? NUM_SLICES : ((v == 1) ? 1 : 2);
        localparam int LW   = SPAN * SLICE_W;
        localparam int NL   = NUM_SLICES / SPAN;
        for (genvar l = 0; l < NL; l++) begin : g_lane
            localparam int LO  = l * LW;
            localparam int TOP = (l + 1) * SPAN - 1;
            logic lane_hi;
            assign lane_hi = lane_top(signed_i, sub_i, opa_i[LO+LW-1],
                                      bx[LO+LW-1], cout_s[TOP]);
            sath_lane_fix #(.LW(LW)) u_fix (
                .sum_i(sum_all[LO +: LW]),
                .top_i(lane_hi),
                .sel_i(sel),
                .res_o(var_res[v][LO +: LW])
            );
        end
    end

    always_comb begin
        case (pk)
            PK_WORD: result_o = var_res[0];
            PK_BYTE: result_o = var_res[1];
            PK_HALF: result_o = var_res[2];
            default: result_o = '0;
        endcase
    end

    assign bad_mode_o = (pk == PK_RSVD);

endmodule

// File: rtl/sath_packed_alu_chk.sv
module sath_packed_alu_chk (
    input logic [31:0] opa_i,
    input logic [31:0] opb_i,
    input logic [1:0]  pack_i,
    input logic        sub_i,
    input logic        signed_i,
    input logic        halve_i,
    input logic [31:0] result_o,
    input logic        bad_mode_o
);
    logic [32:0] wide_sum;
    assign wide_sum = {1'b0, opa_i} + {1'b0, opb_i};

    always_comb begin
        if (pack_i == 2'b11) begin
            p_rsvd_zero_r4: assert (result_o == 32'h0 && bad_mode_o)
                else $error("reserved split must flag and zero");
        end else begin
            p_flag_clear_r4: assert (!bad_mode_o)
                else $error("flag raised for a legal split");
        end

        if (pack_i == 2'b00 && !sub_i && !signed_i && !halve_i) begin
            p_usat_add_r6: assert (result_o >= opa_i && result_o >= opb_i)
                else $error("unsigned saturating add wrapped");
        end

        if (pack_i == 2'b00 && sub_i && !signed_i && !halve_i) begin
            p_usat_sub_r7: assert (result_o <= opa_i)
                else $error("unsigned saturating subtract wrapped");
        end

        if (pack_i == 2'b00 && !sub_i && signed_i && !halve_i
            && opa_i[31] == opb_i[31]) begin
            p_ssat_sign_r5: assert (result_o[31] == opa_i[31])
                else $error("signed saturating add changed sign");
        end

        if (pack_i == 2'b00 && !sub_i && !signed_i && halve_i) begin
            p_uhalf_exact_r8: assert (result_o == wide_sum[32:1])
                else $error("unsigned halving add lost the carry");
        end

        if (pack_i == 2'b01 && !sub_i && !signed_i && !halve_i) begin
            for (int i = 0; i < 4; i++) begin
                p_byte_isolated_r2: assert (result_o[i*8 +: 8] >= opa_i[i*8 +: 8])
                    else $error("byte lane wrapped or leaked a carry");
            end
        end
    end
endmodule

bind sath_packed_alu sath_packed_alu_chk u_chk (
    .opa_i     (opa_i),
    .opb_i     (opb_i),
    .pack_i    (pack_i),
    .sub_i     (sub_i),
    .signed_i  (signed_i),
    .halve_i   (halve_i),
    .result_o  (result_o),
    .bad_mode_o(bad_mode_o)
);

// File: tb/sath_packed_alu_test.sv
module sath_packed_alu_test;

    logic        clk = 1'b0;
    logic [31:0] opa, opb;
    logic [1:0]  pk;
    logic        sub, sgn, hlv;
    logic [31:0] res;
    logic        bad;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    sath_packed_alu uut (
        .opa_i(opa), .opb_i(opb), .pack_i(pk), .sub_i(sub),
        .signed_i(sgn), .halve_i(hlv), .result_o(res), .bad_mode_o(bad)
    );

    // {pack, sub, sgn, halve, a, b, expected result, expected flag}
    localparam int NV = 15;
    localparam logic [101:0] VEC [NV] = '{
        {2'b00, 1'b0, 1'b0, 1'b0, 32'hFFFFFFF0, 32'h00000020, 32'hFFFFFFFF, 1'b0}, // R6
        {2'b00, 1'b0, 1'b1, 1'b0, 32'h7FFFFFFF, 32'h00000001, 32'h7FFFFFFF, 1'b0}, // R5
        {2'b00, 1'b1, 1'b1, 1'b0, 32'h80000000, 32'h00000001, 32'h80000000, 1'b0}, // R5
        {2'b00, 1'b1, 1'b0, 1'b0, 32'h00000005, 32'h00000006, 32'h00000000, 1'b0}, // R7
        {2'b01, 1'b0, 1'b0, 1'b0, 32'h01FF7F80, 32'h01010101, 32'h02FF8081, 1'b0}, // R2 R6
        {2'b01, 1'b0, 1'b1, 1'b0, 32'h01FF7F80, 32'h01010101, 32'h02007F81, 1'b0}, // R2 R5
        {2'b10, 1'b0, 1'b1, 1'b1, 32'h7FFF8001, 32'h0001FFFF, 32'h4000C000, 1'b0}, // R3 R8
        {2'b00, 1'b0, 1'b0, 1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0}, // R8
        {2'b00, 1'b1, 1'b1, 1'b1, 32'h00000000, 32'h00000001, 32'hFFFFFFFF, 1'b0}, // R8
        {2'b01, 1'b0, 1'b1, 1'b1, 32'hFD03FD03, 32'h00000000, 32'hFE01FE01, 1'b0}, // R8
        {2'b11, 1'b0, 1'b0, 1'b0, 32'h12345678, 32'h00000001, 32'h00000000, 1'b1}, // R4
        {2'b10, 1'b1, 1'b0, 1'b0, 32'h00050010, 32'h00060001, 32'h0000000F, 1'b0}, // R3 R7
        {2'b00, 1'b0, 1'b1, 1'b0, 32'h12345678, 32'h11111111, 32'h23456789, 1'b0}, // R9 R1
        {2'b00, 1'b0, 1'b0, 1'b0, 32'h000000FF, 32'h00000001, 32'h00000100, 1'b0}, // R1
        {2'b01, 1'b1, 1'b1, 1'b1, 32'h00000080, 32'h0000007F, 32'h00000080, 1'b0}  // R8
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic apply(input logic [1:0] p, input logic s, input logic g,
                         input logic h, input logic [31:0] a, input logic [31:0] b);
        @(posedge clk);
        pk = p; sub = s; sgn = g; hlv = h; opa = a; opb = b;
        @(negedge clk);
    endtask

    // Behavioural reference: exact per-lane arithmetic in 64-bit integers.
    function automatic logic [31:0] ref_calc(input logic [1:0] p, input logic s,
                                             input logic g, input logic h,
                                             input logic [31:0] a, input logic [31:0] b);
        int w;
        logic [31:0] out;
        if (p == 2'b11) return 32'h0;
        w = (p == 2'b01) ? 8 : ((p == 2'b10) ? 16 : 32);
        out = '0;
        for (int lo = 0; lo < 32; lo += w) begin
            longint mask, xa, xb, r, maxv, minv;
            mask = (64'sd1 <<< w) - 1;
            xa = (longint'(a) >>> lo) & mask;
            xb = (longint'(b) >>> lo) & mask;
            if (g && xa[w-1]) xa = xa - (64'sd1 <<< w);
            if (g && xb[w-1]) xb = xb - (64'sd1 <<< w);
            r = s ? xa - xb : xa + xb;
            if (h) begin
                r = r >>> 1;
            end else begin
                maxv = g ? (64'sd1 <<< (w - 1)) - 1 : mask;
                minv = g ? -(64'sd1 <<< (w - 1)) : 64'sd0;
                if (r > maxv) r = maxv;
                if (r < minv) r = minv;
            end
            out = out | (32'(r & mask) << lo);
        end
        return out;
    endfunction

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                checks++; errors++;
                $display("FAIL watchdog got %0d cycles expected completion", cyc);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] st;
        pk = 2'b00; sub = 0; sgn = 0; hlv = 0; opa = '0; opb = '0;

        // Idle inputs: zero result, flag low (R1, R4)
        apply(2'b00, 0, 0, 0, 32'h0, 32'h0);
        check("R1 idle result", res, 32'h0);
        check("R4 idle flag", {31'b0, bad}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][101:100], VEC[i][99], VEC[i][98], VEC[i][97],
                  VEC[i][96:65], VEC[i][64:33]);
            check($sformatf("R1-9 vector %0d result", i), res, VEC[i][32:1]);
            check($sformatf("R4 vector %0d flag", i), {31'b0, bad}, {31'b0, VEC[i][0]});
        end

        // R2: carry out of byte 0 must not reach byte 1 (unsigned halve add)
        apply(2'b01, 0, 0, 1, 32'h000000FF, 32'h00000001);
        check("R2 byte carry isolation", res, 32'h00000080);
        // R3: half lanes break at bit 16 but not at bit 8
        apply(2'b10, 0, 0, 0, 32'h00FF00FF, 32'h00010001);
        check("R3 half carry through bit 8", res, 32'h01000100);
        // R1: borrow ripples through all 32 bits
        apply(2'b00, 1, 1, 0, 32'h00010000, 32'h00000001);
        check("R1 word borrow ripple", res, 32'h0000FFFF);
        // R4: reserved split ignores every control combination
        apply(2'b11, 1, 1, 1, 32'hFFFFFFFF, 32'h80000000);
        check("R4 reserved result", res, 32'h0);
        check("R4 reserved flag", {31'b0, bad}, 32'h1);
        // R5: half-word negative overflow clamps to 0x8000
        apply(2'b10, 1, 1, 0, 32'h80000001, 32'h00010002);
        check("R5 half signed clamp", res, 32'h8000FFFF);

        // Random sweep against the reference (R1..R9)
        st = 32'h1D2C3B4A;
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a, b, c;
            st = st ^ (st << 13); st = st ^ (st >> 17); st = st ^ (st << 5); a = st;
            st = st ^ (st << 13); st = st ^ (st >> 17); st = st ^ (st << 5); b = st;
            st = st ^ (st << 13); st = st ^ (st >> 17); st = st ^ (st << 5); c = st;
            if (c[8]) b = a ^ {24'h0, c[31:24]};
            apply(c[1:0], c[2], c[3], c[4], a, b);
            check($sformatf("R1-9 random %0d result", i), res,
                  ref_calc(c[1:0], c[2], c[3], c[4], a, b));
            check($sformatf("R4 random %0d flag", i), {31'b0, bad},
                  {31'b0, c[1:0] == 2'b11});
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule